// File: doc/BRIEF.md
# Codec register access sequencer

This block drives the command side of a serial audio codec link. It sits above a frame transceiver that presents one received frame (a 16-bit tag and four 20-bit slots) together with a one-cycle `frame_i` strobe. On each strobe it decides the content of the next outgoing frame and registers it for the transceiver to shift out. After its own reset it first holds the codec in reset for a fixed number of clock cycles. It then waits for the codec to flag readiness in the received tag, and then writes a short initialisation list, one entry per ready frame.

Once the list is written, the block serves host requests. A host write goes out as one command frame. A host read goes out as one command frame, and the block then watches later received frames for a status frame that carries the requested address. When a status frame matches, the read data is captured and the request completes. If no match arrives within a bounded number of frames, the request ends with an error. Frames that carry no command keep the audio path alive: the received left and right samples are looped back to the outgoing sample slots.

Top module: `codec_seq_top`

## Requirements
- R1: After `rst_ni` is released, `codec_rst_no` stays low for exactly RST_CYCLES clock edges (default 20) and then stays high. While it is low, the outgoing tag is zero and `req_ready_o` is low.
- R2: On any frame whose received tag bit 15 (ready) is 0, the next outgoing tag and all four outgoing slots are zero, and no command is consumed.
- R3: Initialisation entry i (0-based, INIT_LEN entries, default 4) is a write to address 2*(i+1) with data 0x1111*(i+1). Each ready frame sends the next entry. `req_ready_o` rises only after the last entry has been sent, and initialisation raises no `done_o`.
- R4: A write command frame has tag 0xF800. Slot 1 has bit 19 = 0, bits 18:12 = address and all other bits zero. Slot 2 has bits 19:4 = data and bits 3:0 zero.
- R5: A read command frame has tag 0xC000 and slot 1 bit 19 = 1 with bits 18:12 = address. Slots 2, 3 and 4 are zero.
- R6: A frame with no command has tag 0x9800 and zero slots 1 and 2. In both idle and write frames, outgoing slots 3 and 4 equal the received slots 3 and 4 with bits 3:0 cleared. Outputs change only on a `frame_i` cycle.
- R7: A host command is sent in exactly one ready frame; the following frame is idle. A write completes with a one-cycle `done_o` in the cycle after the frame that carries it, with `err_o` low.
- R8: A received frame whose tag bits 15, 14 and 13 are all set is a status frame. If its slot 1 bits 18:12 equal the pending read address, `rd_data_o` takes slot 2 bits 19:4 and `done_o` pulses with `err_o` low. Status frames with another address, and frames without that tag pattern, leave `rd_data_o` unchanged and do not complete the read.
- R9: If TIMEOUT_FRAMES frames (default 16) follow a read command without a match, `done_o` and `err_o` pulse together after the last of them, and `rd_data_o` keeps its value.
- R10: `req_ready_o` falls in the cycle after a request is accepted and stays low until that request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| codec_rst_no | output | 1 | Codec reset, active low |
| frame_i | input | 1 | One-cycle strobe: received frame fields valid |
| rx_tag_i | input | 16 | Received tag |
| rx_slot1_i | input | 20 | Received slot 1 (status address) |
| rx_slot2_i | input | 20 | Received slot 2 (status data) |
| rx_slot3_i | input | 20 | Received left sample |
| rx_slot4_i | input | 20 | Received right sample |
| tx_tag_o | output | 16 | Outgoing tag |
| tx_slot1_o | output | 20 | Outgoing command address slot |
| tx_slot2_o | output | 20 | Outgoing command data slot |
| tx_slot3_o | output | 20 | Outgoing left sample |
| tx_slot4_o | output | 20 | Outgoing right sample |
| req_valid_i | input | 1 | Host request valid |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | 7 | Register address |
| req_data_i | input | 16 | Write data |
| req_ready_o | output | 1 | Request can be accepted |
| done_o | output | 1 | One-cycle request completion |
| err_o | output | 1 | Read timed out (with done_o) |
| rd_data_o | output | 16 | Last captured read data |

## Verification
The sequencer state shows up in the very next outgoing frame. A wrong initialisation index, a skipped entry or an entry consumed on a not-ready frame appears as a wrong address or data in the frame after the strobe. A lost or doubled pending command appears as a missing or repeated command frame, or as a `done_o` one frame early or late. A wrong timeout count or a wrong address compare moves the error pulse off the 16th frame, or captures data from a foreign status frame. The bench can see each of these within one or two frames.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;

  localparam logic [TAG_W-1:0] TAG_IDLE = 16'h9800;
  localparam logic [TAG_W-1:0] TAG_WR   = 16'hF800;
  localparam logic [TAG_W-1:0] TAG_RD   = 16'hC000;

  typedef enum logic [1:0] {ST_HOLD, ST_INIT, ST_RUN, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic              vld;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic [ADDR_W-1:0] init_addr(int idx);
    return ADDR_W'(2 * (idx + 1));
  endfunction

  function automatic logic [DATA_W-1:0] init_data(int idx);
    return DATA_W'(32'h1111 * (idx + 1));
  endfunction
endpackage

// File: rtl/codec_seq_rst_timer.sv
module codec_seq_rst_timer #(
  parameter int RST_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic released_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == LAST) rel_q <= 1'b1;
    end
  end

  assign released_o = rel_q;
endmodule

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
  import codec_seq_pkg::*;
#(
  parameter int INIT_LEN       = 4,
  parameter int TIMEOUT_FRAMES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              released_i,
  input  logic              frame_i,
  input  logic              codec_rdy_i,
  input  logic              stat_vld_i,
  input  logic [ADDR_W-1:0] stat_addr_i,
  input  logic [DATA_W-1:0] stat_data_i,
  input  logic              req_valid_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              hold_o,
  output cmd_t              cmd_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int IW = (INIT_LEN > 1) ? $clog2(INIT_LEN) : 1;
  localparam int TW = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1;
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_LEN - 1);
  localparam logic [TW-1:0] TO_LAST   = TW'(TIMEOUT_FRAMES - 1);

  seq_state_e        st_q;
  logic [IW-1:0]     idx_q;
  logic [TW-1:0]     tcnt_q;
  logic              pend_q, prd_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;
  logic              done_q, err_q;
  logic [DATA_W-1:0] rdata_q;
  logic              fire_init, fire_host, accept;

  assign fire_init   = (st_q == ST_INIT) && codec_rdy_i;
  assign fire_host   = (st_q == ST_RUN) && pend_q && codec_rdy_i;
  assign req_ready_o = (st_q == ST_RUN) && !pend_q;
  assign accept      = req_valid_i && req_ready_o;
  assign hold_o      = (st_q == ST_HOLD);

  always_comb begin
    cmd_o = '0;
    if (fire_init) begin
      cmd_o.vld  = 1'b1;
      cmd_o.addr = init_addr(int'(idx_q));
      cmd_o.data = init_data(int'(idx_q));
    end else if (fire_host) begin
      cmd_o.vld  = 1'b1;
      cmd_o.rd   = prd_q;
      cmd_o.addr = paddr_q;
      cmd_o.data = prd_q ? '0 : pdata_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HOLD;
      idx_q   <= '0;
      tcnt_q  <= '0;
      pend_q  <= 1'b0;
      prd_q   <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_HOLD: if (released_i) st_q <= ST_INIT;
        ST_INIT: begin
          if (frame_i && fire_init) begin
            if (idx_q == INIT_LAST) st_q <= ST_RUN;
            else idx_q <= idx_q + IW'(1);
          end
        end
        ST_RUN: begin
          if (accept) begin
            pend_q  <= 1'b1;
            prd_q   <= req_rd_i;
            paddr_q <= req_addr_i;
            pdata_q <= req_data_i;
          end else if (frame_i && fire_host) begin
            pend_q <= 1'b0;
            if (prd_q) begin
              st_q   <= ST_WAIT;
              tcnt_q <= '0;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (frame_i) begin
            if (stat_vld_i && (stat_addr_i == paddr_q)) begin
              rdata_q <= stat_data_i;
              done_q  <= 1'b1;
              st_q    <= ST_RUN;
            end else if (tcnt_q == TO_LAST) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              st_q   <= ST_RUN;
            end else begin
              tcnt_q <= tcnt_q + TW'(1);
            end
          end
        end
        default: st_q <= ST_HOLD;
      endcase
    end
  end

  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rd_data_o = rdata_q;
endmodule

// File: rtl/codec_seq_frame.sv
module codec_seq_frame
  import codec_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              hold_i,
  input  cmd_t              cmd_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic [SLOT_W-1:0] rx_slot2_i,
  input  logic [SLOT_W-1:0] rx_slot3_i,
  input  logic [SLOT_W-1:0] rx_slot4_i,
  output logic [TAG_W-1:0]  tx_tag_o,
  output logic [SLOT_W-1:0] tx_slot1_o,
  output logic [SLOT_W-1:0] tx_slot2_o,
  output logic [SLOT_W-1:0] tx_slot3_o,
  output logic [SLOT_W-1:0] tx_slot4_o,
  output logic              codec_rdy_o,
  output logic              stat_vld_o,
  output logic [ADDR_W-1:0] stat_addr_o,
  output logic [DATA_W-1:0] stat_data_o
);
  localparam int LSB_PAD = SLOT_W - 1 - ADDR_W;
  localparam int DAT_PAD = SLOT_W - DATA_W;

  logic [TAG_W-1:0]  n_tag;
  logic [SLOT_W-1:0] n_s1, n_s2, n_s3, n_s4, pcm_l, pcm_r;
  logic              unused_rx;

  assign codec_rdy_o = rx_tag_i[TAG_W-1];
  assign stat_vld_o  = &rx_tag_i[TAG_W-1:TAG_W-3];
  assign stat_addr_o = rx_slot1_i[SLOT_W-2 -: ADDR_W];
  assign stat_data_o = rx_slot2_i[SLOT_W-1 -: DATA_W];
  assign pcm_l       = {rx_slot3_i[SLOT_W-1:4], 4'b0};
  assign pcm_r       = {rx_slot4_i[SLOT_W-1:4], 4'b0};
  assign unused_rx   = ^{rx_tag_i[TAG_W-4:0], rx_slot1_i[SLOT_W-1],
                         rx_slot1_i[LSB_PAD-1:0], rx_slot2_i[DAT_PAD-1:0],
                         rx_slot3_i[3:0], rx_slot4_i[3:0]};

  always_comb begin
    n_tag = '0; n_s1 = '0; n_s2 = '0; n_s3 = '0; n_s4 = '0;
    if (!hold_i && codec_rdy_o) begin
      if (cmd_i.vld && cmd_i.rd) begin
        n_tag = TAG_RD;
        n_s1  = {1'b1, cmd_i.addr, {LSB_PAD{1'b0}}};
      end else begin
        n_s3 = pcm_l;
        n_s4 = pcm_r;
        if (cmd_i.vld) begin
          n_tag = TAG_WR;
          n_s1  = {1'b0, cmd_i.addr, {LSB_PAD{1'b0}}};
          n_s2  = {cmd_i.data, {DAT_PAD{1'b0}}};
        end else begin
          n_tag = TAG_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_tag_o   <= '0;
      tx_slot1_o <= '0;
      tx_slot2_o <= '0;
      tx_slot3_o <= '0;
      tx_slot4_o <= '0;
    end else if (frame_i) begin
      tx_tag_o   <= n_tag;
      tx_slot1_o <= n_s1;
      tx_slot2_o <= n_s2;
      tx_slot3_o <= n_s3;
      tx_slot4_o <= n_s4;
    end
  end
endmodule

// File: rtl/codec_seq_top.sv
module codec_seq_top
  import codec_seq_pkg::*;
#(
  parameter int RST_CYCLES     = 20,
  parameter int INIT_LEN       = 4,
  parameter int TIMEOUT_FRAMES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              codec_rst_no,
  input  logic              frame_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic [SLOT_W-1:0] rx_slot2_i,
  input  logic [SLOT_W-1:0] rx_slot3_i,
  input  logic [SLOT_W-1:0] rx_slot4_i,
  output logic [TAG_W-1:0]  tx_tag_o,
  output logic [SLOT_W-1:0] tx_slot1_o,
  output logic [SLOT_W-1:0] tx_slot2_o,
  output logic [SLOT_W-1:0] tx_slot3_o,
  output logic [SLOT_W-1:0] tx_slot4_o,
  input  logic              req_valid_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              released, hold, codec_rdy, stat_vld;
  logic [ADDR_W-1:0] stat_addr;
  logic [DATA_W-1:0] stat_data;
  cmd_t              cmd;

  codec_seq_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .released_o(released)
  );

  codec_seq_ctrl #(.INIT_LEN(INIT_LEN), .TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .released_i(released), .frame_i(frame_i),
    .codec_rdy_i(codec_rdy), .stat_vld_i(stat_vld), .stat_addr_i(stat_addr),
    .stat_data_i(stat_data), .req_valid_i(req_valid_i), .req_rd_i(req_rd_i),
    .req_addr_i(req_addr_i), .req_data_i(req_data_i), .req_ready_o(req_ready_o),
    .hold_o(hold), .cmd_o(cmd), .done_o(done_o), .err_o(err_o), .rd_data_o(rd_data_o)
  );

  codec_seq_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .hold_i(hold), .cmd_i(cmd),
    .rx_tag_i(rx_tag_i), .rx_slot1_i(rx_slot1_i), .rx_slot2_i(rx_slot2_i),
    .rx_slot3_i(rx_slot3_i), .rx_slot4_i(rx_slot4_i),
    .tx_tag_o(tx_tag_o), .tx_slot1_o(tx_slot1_o), .tx_slot2_o(tx_slot2_o),
    .tx_slot3_o(tx_slot3_o), .tx_slot4_o(tx_slot4_o),
    .codec_rdy_o(codec_rdy), .stat_vld_o(stat_vld), .stat_addr_o(stat_addr),
    .stat_data_o(stat_data)
  );

  assign codec_rst_no = released;
endmodule

// File: rtl/codec_seq_chk.sv
module codec_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        codec_rst_no,
  input logic        frame_i,
  input logic [15:0] rx_tag_i,
  input logic [19:0] tx_slot1_o,
  input logic [19:0] tx_slot2_o,
  input logic [19:0] tx_slot3_o,
  input logic [19:0] tx_slot4_o,
  input logic [15:0] tx_tag_o,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        err_o
);
  AST_RST_STAYS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codec_rst_no |=> codec_rst_no); // R1

  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !codec_rst_no |-> (tx_tag_o == 16'h0 && !req_ready_o)); // R1

  AST_ZERO_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !rx_tag_i[15]) |=> (tx_tag_o == 16'h0 && tx_slot1_o == 20'h0 &&
      tx_slot2_o == 20'h0 && tx_slot3_o == 20'h0 && tx_slot4_o == 20'h0)); // R2

  AST_READ_SLOTS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_slot1_o[19] |-> (tx_tag_o == 16'hC000 && tx_slot2_o == 20'h0 &&
      tx_slot3_o == 20'h0 && tx_slot4_o == 20'h0)); // R5

  AST_TX_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable({tx_tag_o, tx_slot1_o, tx_slot2_o, tx_slot3_o, tx_slot4_o})); // R6

  AST_DONE_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> !done_o); // R7

  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
endmodule

bind codec_seq_top codec_seq_chk u_chk (.*);

// File: tb/tb_codec_seq_top.sv
`timescale 1ns/1ps
module tb_codec_seq_top;
  localparam int RST_CYCLES = 20;
  localparam int INIT_LEN   = 4;
  localparam int TIMEOUT    = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        codec_rst_no;
  logic        frame_i = 1'b0;
  logic [15:0] rx_tag_i = '0;
  logic [19:0] rx_slot1_i = '0, rx_slot2_i = '0, rx_slot3_i = '0, rx_slot4_i = '0;
  logic [15:0] tx_tag_o;
  logic [19:0] tx_slot1_o, tx_slot2_o, tx_slot3_o, tx_slot4_o;
  logic        req_valid_i = 1'b0, req_rd_i = 1'b0;
  logic [6:0]  req_addr_i = '0;
  logic [15:0] req_data_i = '0;
  logic        req_ready_o, done_o, err_o;
  logic [15:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] last_rd = '0;

  always #4 clk = ~clk;

  codec_seq_top #(.RST_CYCLES(RST_CYCLES), .INIT_LEN(INIT_LEN), .TIMEOUT_FRAMES(TIMEOUT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .codec_rst_no(codec_rst_no), .frame_i(frame_i),
    .rx_tag_i(rx_tag_i), .rx_slot1_i(rx_slot1_i), .rx_slot2_i(rx_slot2_i),
    .rx_slot3_i(rx_slot3_i), .rx_slot4_i(rx_slot4_i),
    .tx_tag_o(tx_tag_o), .tx_slot1_o(tx_slot1_o), .tx_slot2_o(tx_slot2_o),
    .tx_slot3_o(tx_slot3_o), .tx_slot4_o(tx_slot4_o),
    .req_valid_i(req_valid_i), .req_rd_i(req_rd_i), .req_addr_i(req_addr_i),
    .req_data_i(req_data_i), .req_ready_o(req_ready_o), .done_o(done_o),
    .err_o(err_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [19:0] pcm(input logic [19:0] x);
    return {x[19:4], 4'b0};
  endfunction

  task automatic frame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4);
    @(negedge clk);
    rx_tag_i = tag; rx_slot1_i = s1; rx_slot2_i = s2; rx_slot3_i = s3; rx_slot4_i = s4;
    frame_i = 1'b1;
    @(negedge clk);
    frame_i = 1'b0;
  endtask

  task automatic check_tx(input string req, input logic [15:0] tag,
                          input logic [19:0] s1, s2, s3, s4);
    check({req, " tag"}, 32'(tx_tag_o), 32'(tag));
    check({req, " slot1"}, 32'(tx_slot1_o), 32'(s1));
    check({req, " slot2"}, 32'(tx_slot2_o), 32'(s2));
    check({req, " slot3"}, 32'(tx_slot3_o), 32'(s3));
    check({req, " slot4"}, 32'(tx_slot4_o), 32'(s4));
  endtask

  task automatic host(input logic rd, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    check("R10 ready before request", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; req_rd_i = rd; req_addr_i = a; req_data_i = d;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R10 ready low after accept", 32'(req_ready_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [19:0] l, r;
    #20;
    check("R1 reset codec_rst_no", 32'(codec_rst_no), 32'd0);
    check("R1 reset ready", 32'(req_ready_o), 32'd0);
    check("R1 reset tag", 32'(tx_tag_o), 32'd0);
    check("R1 reset done", 32'(done_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 1; k <= RST_CYCLES + 2; k++) begin
      @(negedge clk);
      if (k >= RST_CYCLES - 1)
        check("R1 release timing", 32'(codec_rst_no), 32'(k >= RST_CYCLES));
    end

    // R2: not-ready frame before init
    frame(16'h0000, 20'h12345, 20'h6789A, 20'hABCDE, 20'h13579);
    check_tx("R2 not ready", 16'h0, 20'h0, 20'h0, 20'h0, 20'h0);

    // R3: initialisation list
    for (int i = 0; i < INIT_LEN; i++) begin
      if (i == 1) begin
        frame(16'h7FFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF);
        check_tx("R2 gap in init", 16'h0, 20'h0, 20'h0, 20'h0, 20'h0);
      end
      l = 20'(32'h0F0F3 * (i + 1)); r = 20'(32'h7A5C1 + i);
      frame(16'h8000, 20'h0, 20'h0, l, r);
      check_tx("R3 init entry", 16'hF800, {1'b0, 7'(2 * (i + 1)), 12'h0},
               {16'(32'h1111 * (i + 1)), 4'h0}, pcm(l), pcm(r));
      check("R3 no done in init", 32'(done_o), 32'd0);
      check("R3 ready after init", 32'(req_ready_o), 32'(i == INIT_LEN - 1));
    end

    // R6: idle frames, loopback sweep
    for (int j = 0; j < 10; j++) begin
      l = 20'hFFFFF >> j; r = 20'(32'h00001 << (2 * j)) | 20'h0000F;
      frame(16'h8000, 20'h0, 20'h0, l, r);
      check_tx("R6 idle", 16'h9800, 20'h0, 20'h0, pcm(l), pcm(r));
    end

    // R4/R7: writes to every address
    for (int a = 0; a < 128; a++) begin
      logic [15:0] d;
      d = 16'(a * 32'h0203) ^ 16'hA5A5;
      host(1'b0, 7'(a), d);
      if (a == 5) begin
        frame(16'h0000, 20'h0, 20'h0, 20'h1234F, 20'h0);
        check_tx("R2 pending write held", 16'h0, 20'h0, 20'h0, 20'h0, 20'h0);
        check("R2 no done when held", 32'(done_o), 32'd0);
      end
      l = 20'(a * 32'h1357); r = 20'(32'hFFFFF - a);
      frame(16'h8000, 20'h0, 20'h0, l, r);
      check_tx("R4 write frame", 16'hF800, {1'b0, 7'(a), 12'h0}, {d, 4'h0}, pcm(l), pcm(r));
      check("R7 write done", 32'(done_o), 32'd1);
      check("R7 write err", 32'(err_o), 32'd0);
      frame(16'h8000, 20'h0, 20'h0, l, r);
      check("R7 one frame only", 32'(tx_tag_o), 32'h9800);
      check("R7 done single", 32'(done_o), 32'd0);
    end

    // R5/R8: reads of every address
    for (int a = 0; a < 128; a++) begin
      logic [15:0] d;
      d = 16'(a * 32'h0B17) ^ 16'h3C3C;
      host(1'b1, 7'(a), 16'hFFFF);
      frame(16'h8000, 20'h0, 20'h0, 20'hFFFFF, 20'hFFFFF);
      check_tx("R5 read frame", 16'hC000, {1'b1, 7'(a), 12'h0}, 20'h0, 20'h0, 20'h0);
      check("R5 no done yet", 32'(done_o), 32'd0);
      frame(16'hE000, {1'b0, 7'(a) ^ 7'h01, 12'h0}, {16'hDEAD, 4'h0}, 20'h0, 20'h0);
      check("R8 wrong addr no done", 32'(done_o), 32'd0);
      check("R8 wrong addr keeps data", 32'(rd_data_o), 32'(last_rd));
      if (a % 16 == 0) begin
        frame(16'hC000, {1'b0, 7'(a), 12'h0}, {16'hBEEF, 4'h0}, 20'h0, 20'h0);
        check("R8 non-status tag ignored", 32'(done_o), 32'd0);
        check("R8 non-status keeps data", 32'(rd_data_o), 32'(last_rd));
      end
      frame(16'hE000, {1'b0, 7'(a), 12'hFFF}, {d, 4'hF}, 20'h0, 20'h0);
      check("R8 read done", 32'(done_o), 32'd1);
      check("R8 read err", 32'(err_o), 32'd0);
      check("R8 read data", 32'(rd_data_o), 32'(d));
      check("R10 ready after read", 32'(req_ready_o), 32'd1);
      last_rd = d;
    end

    // R9: timeout
    host(1'b1, 7'h33, 16'h0);
    frame(16'h8000, 20'h0, 20'h0, 20'h0, 20'h0);
    check("R9 read sent", 32'(tx_tag_o), 32'hC000);
    for (int j = 1; j <= TIMEOUT; j++) begin
      frame(16'hE000, {1'b0, 7'h34, 12'h0}, {16'h5555, 4'h0}, 20'h0, 20'h0);
      check("R9 done timing", 32'(done_o), 32'(j == TIMEOUT));
      check("R9 err timing", 32'(err_o), 32'(j == TIMEOUT));
      if (j < TIMEOUT) check("R10 busy while waiting", 32'(req_ready_o), 32'd0);
    end
    check("R9 data kept", 32'(rd_data_o), 32'(last_rd));
    check("R9 ready after timeout", 32'(req_ready_o), 32'd1);

    report();
    $finish;
  end
endmodule